// File: doc/BRIEF.md
# Top-N Class Pattern Selector

This block turns a vector of H unsigned recall scores into a binary class pattern. Exactly as many bits are set as the requested winner count allows, and they sit at the highest scores. It sits between a binary-link associative memory's first stage, which produces per-column link counts from a key, and the second stage, which expects a clean class pattern. A fixed or key-derived threshold fails when a noisy or occluded key adds stray active rows. Picking by rank still recovers the taught class pattern in that case, because every class pattern was taught with the same number of ones.

A request (score vector plus winner count N) enters over a valid/ready handshake and is captured in full on acceptance. The block then runs one selection pass per clock. Each pass takes the largest score not yet chosen, with ties going to the lower element index, and stops after N passes or when nothing is left. The result leaves over a second valid/ready handshake. Back-pressure works as follows: `in_ready` is high only while the block is idle, and a presented result stays on `out_mask` with `out_valid` high until `out_ready` takes it. Only one request is in flight at a time. Only comparisons are used; no sums or thresholds are computed.

Top module: `topn_select`

## Requirements
- R1: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high after reset and whenever no request is being processed or held at the output.
- R2: The delivered `out_mask` has exactly min(N, H) bits set, where N is the value of `in_n` at acceptance.
- R3: Element i's score is `in_counts[i*CW +: CW]`. Bit i of `out_mask` is the decision for element i. No clear bit has a score strictly greater than any set bit's score.
- R4: Among elements with equal scores, a set bit never sits at a higher index than a clear one. Ties go to the lower index.
- R5: N = 0 gives an all-zero `out_mask`.
- R6: N >= H, including values of `in_n` above H, gives an all-ones `out_mask`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_mask` stays unchanged. The result is released on the first edge with `out_ready` high, and `in_ready` returns high after that edge.
- R8: Counting the acceptance edge as edge 0, `out_valid` is first high after edge max(N, 0) for N <= H. For N > H it is first high after edge H+1. With N = 0 this is right after the acceptance edge.
- R9: Changes on `in_counts` and `in_n` after the acceptance edge do not affect the result of the request in flight.
- R10: Scores from a noisy key are handled by rank, not by threshold. With H=16, N=2, scores 3 at element 2, 2 at element 5 and 1 or 0 elsewhere, the result is 16'h0024, although a threshold of 3 would drop element 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_counts | input | H*CW | Packed scores, element i at bits [i*CW +: CW] |
| in_n | input | NW | Winner count, NW = $clog2(H+1) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | H | Class pattern, bit i for element i |

## Verification
The ranking and popcount assertions are evaluated against the block's captured copy of the scores and the clipped winner count, not against the input pins. They therefore assume the result is judged against what was sampled at acceptance, and they tolerate any later activity on `in_counts` and `in_n`. They also assume `out_ready` is a clean 0/1 level. The stimulus drops `in_valid` and scrambles both inputs right after every acceptance. It draws scores from a narrow range so that ties are frequent. It keeps the winner count between 0 and a few above H, so the clipped all-ones case is reached without exceeding the `in_n` width.

// File: rtl/topn_pkg.sv
package topn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } topn_state_e;

endpackage

// File: rtl/topn_argmax.sv
// Combinational max finder over eligible elements; ties resolve to lower index.
module topn_argmax #(
  parameter int H  = 16,
  parameter int CW = 8,
  localparam int IW = (H > 1) ? $clog2(H) : 1
) (
  input  logic [H*CW-1:0] vals,
  input  logic [H-1:0]    elig,
  output logic            found,
  output logic [IW-1:0]   idx
);
  localparam int LV = IW;
  localparam int P  = 1 << LV;
  localparam int NN = 2 * P - 1;

  logic [CW-1:0] nv  [NN];
  logic [IW-1:0] ni  [NN];
  logic          nok [NN];

  // leaves: heap slot P-1+g holds element g, so left subtrees cover lower indices
  for (genvar g = 0; g < P; g++) begin : g_leaf
    if (g < H) begin : g_real
      assign nv[P-1+g]  = vals[g*CW +: CW];
      assign ni[P-1+g]  = IW'(g);
      assign nok[P-1+g] = elig[g];
    end else begin : g_pad
      assign nv[P-1+g]  = '0;
      assign ni[P-1+g]  = '0;
      assign nok[P-1+g] = 1'b0;
    end
  end

  for (genvar k = 0; k < P - 1; k++) begin : g_node
    logic take_l;
    assign take_l = nok[2*k+1] && (!nok[2*k+2] || (nv[2*k+1] >= nv[2*k+2]));
    assign nv[k]  = take_l ? nv[2*k+1] : nv[2*k+2];
    assign ni[k]  = take_l ? ni[2*k+1] : ni[2*k+2];
    assign nok[k] = nok[2*k+1] || nok[2*k+2];
  end

  assign found = nok[0];
  assign idx   = ni[0];

endmodule

// File: rtl/topn_ctrl.sv
// Request capture, one selection pass per cycle, result hold.
module topn_ctrl
  import topn_pkg::*;
#(
  parameter int H  = 16,
  parameter int CW = 8,
  localparam int NW = $clog2(H + 1),
  localparam int IW = (H > 1) ? $clog2(H) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [H*CW-1:0] in_counts,
  input  logic [NW-1:0]   in_n,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [H-1:0]    out_mask,
  output logic [H*CW-1:0] cnt_q,
  output logic [H-1:0]    elig,
  input  logic            found,
  input  logic [IW-1:0]   idx
);
  topn_state_e   state;
  logic [H-1:0]  sel;
  logic [NW-1:0] rem;
  logic [NW-1:0] n_tgt;
  logic          accept;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_mask  = sel;
  assign elig      = ~sel;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sel   <= '0;
      rem   <= '0;
      n_tgt <= '0;
      cnt_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cnt_q <= in_counts;
            sel   <= '0;
            rem   <= in_n;
            n_tgt <= (in_n > NW'(H)) ? NW'(H) : in_n;
            state <= (in_n == '0) ? ST_DONE : ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!found) begin
            state <= ST_DONE;
          end else begin
            sel[idx] <= 1'b1;
            rem      <= rem - NW'(1);
            if (rem == NW'(1)) state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent ranking check over the captured scores.
  function automatic logic rank_ok(input logic [H-1:0] m, input logic [H*CW-1:0] c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < H; i++) begin
      for (int j = 0; j < H; j++) begin
        if (m[i] && !m[j]) begin
          if (c[j*CW +: CW] > c[i*CW +: CW]) ok = 1'b0;
          if ((c[j*CW +: CW] == c[i*CW +: CW]) && (j < i)) ok = 1'b0;
        end
      end
    end
    return ok;
  endfunction

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_popcount_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_mask) == int'(n_tgt)));

  p_rank_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rank_ok(out_mask, cnt_q));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (n_tgt == '0)) |-> (out_mask == '0));

  p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (n_tgt == NW'(H))) |-> (&out_mask));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask)));

endmodule

// File: rtl/topn_select.sv
module topn_select #(
  parameter int H  = 16,
  parameter int CW = 8,
  localparam int NW = $clog2(H + 1),
  localparam int IW = (H > 1) ? $clog2(H) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [H*CW-1:0] in_counts,
  input  logic [NW-1:0]   in_n,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [H-1:0]    out_mask
);
  logic [H*CW-1:0] cnt_q;
  logic [H-1:0]    elig;
  logic            found;
  logic [IW-1:0]   idx;

  topn_ctrl #(.H(H), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_counts (in_counts),
    .in_n      (in_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_mask  (out_mask),
    .cnt_q     (cnt_q),
    .elig      (elig),
    .found     (found),
    .idx       (idx)
  );

  topn_argmax #(.H(H), .CW(CW)) u_argmax (
    .vals  (cnt_q),
    .elig  (elig),
    .found (found),
    .idx   (idx)
  );

endmodule

// File: tb/topn_select_test.sv
`timescale 1ns/1ps
module topn_select_test;
  localparam int H  = 16;
  localparam int CW = 8;
  localparam int NW = $clog2(H + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [H*CW-1:0] in_counts = '0;
  logic [NW-1:0]   in_n = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [H-1:0]    out_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  topn_select #(.H(H), .CW(CW)) uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference: repeated pick of the highest unpicked score, lowest index first.
  function automatic logic [H-1:0] ref_mask(input logic [H*CW-1:0] c, input int n);
    logic [H-1:0] m;
    m = '0;
    for (int p = 0; p < n && p < H; p++) begin
      int best;
      best = -1;
      for (int i = 0; i < H; i++)
        if (!m[i] && (best < 0 || c[i*CW +: CW] > c[best*CW +: CW])) best = i;
      if (best >= 0) m[best] = 1'b1;
    end
    return m;
  endfunction

  task automatic run(input logic [H*CW-1:0] c, input int n, input int hold);
    logic [H-1:0] exp_m;
    int edges, exp_edges;
    exp_m = ref_mask(c, n);
    exp_edges = (n == 0) ? 0 : ((n <= H) ? n : H + 1);
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready before request", 32'(in_ready), 32'd1);
    in_valid  = 1'b1;
    in_counts = c;
    in_n      = NW'(n);
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    in_counts = {H{8'hFF}};      // R9: scramble after acceptance
    in_n      = NW'(n == 0 ? H : 0);
    edges = 0;
    while (out_valid !== 1'b1 && edges < 4 * H) begin
      @(posedge clk);
      #1;
      edges++;
    end
    check(edges == exp_edges, "R8 latency", 32'(edges), 32'(exp_edges));
    check(out_mask === exp_m, "R2/R3/R4/R9 mask", 32'(out_mask), 32'(exp_m));
    check($countones(out_mask) == ((n < H) ? n : H), "R2 popcount",
          32'($countones(out_mask)), 32'((n < H) ? n : H));
    for (int k = 0; k < hold; k++) begin
      @(posedge clk);
      #1;
      check(out_valid === 1'b1 && out_mask === exp_m, "R7 hold under back-pressure",
            32'(out_mask), 32'(exp_m));
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R7 release", 32'({out_valid, in_ready}), 32'b01);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [H*CW-1:0] c;
    void'($urandom(32'h5EED_0101));
    #12;
    check(in_ready === 1'b1 && out_valid === 1'b0 && out_mask === '0, "R1 reset state",
          32'({in_ready, out_valid}), 32'b10);
    rst_n = 1'b1;

    // R5: zero winners
    c = '0;
    for (int i = 0; i < H; i++) c[i*CW +: CW] = CW'(i + 1);
    run(c, 0, 1);
    check(out_mask === '0, "R5 zero winners", 32'(out_mask), 32'd0);

    // R6: N equal to H and above H
    run(c, H, 0);
    check(out_mask === '1, "R6 N equals H", 32'(out_mask), 32'hFFFF);
    run(c, H + 3, 2);
    check(out_mask === '1, "R6 N above H", 32'(out_mask), 32'hFFFF);

    // R4: all scores equal -> lowest indices win
    c = {H{8'd5}};
    run(c, 3, 0);
    check(out_mask === 16'h0007, "R4 all tied", 32'(out_mask), 32'h0007);

    // R10: noisy key, rank beats threshold of 3
    c = '0;
    for (int i = 0; i < H; i++) c[i*CW +: CW] = CW'(i % 2);
    c[2*CW +: CW] = 8'd3;
    c[5*CW +: CW] = 8'd2;
    run(c, 2, 0);
    check(out_mask === 16'h0024, "R10 noisy key", 32'(out_mask), 32'h0024);

    // R3: descending scores, top end at low indices
    for (int i = 0; i < H; i++) c[i*CW +: CW] = CW'(200 - i * 7);
    run(c, 1, 0);
    check(out_mask === 16'h0001, "R3 single winner", 32'(out_mask), 32'h0001);

    // Random mix, narrow score range for ties
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < H; i++) c[i*CW +: CW] = CW'($urandom_range(0, 7));
      run(c, $urandom_range(0, H + 2), $urandom_range(0, 2));
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule